// File: doc/BRIEF.md
# Page Write Collector and Programming Sequencer

This block sits between a serial-bus protocol engine and a non-volatile array. During a write transfer it captures up to eight data bytes into a small page latch, steering each byte by the low three bits of the current word address. When the transfer ends with a STOP it decides whether to program. If it programs, it runs a timed sequence against a plain array write port: one page erase, then one program step for each latch entry that was loaded.

The protocol engine reports four events: a word address has arrived, a data byte has arrived, STOP was seen, and START was seen. For each data byte the block answers at once with an acknowledge-allowed flag. The step time comes from an oscillator tick divided by two parameterized ratios. Their defaults are 128 and 16. A bench can make them smaller to shorten the steps. While the sequence runs, `busy` is high and every event from the protocol engine is ignored.

Top module: `page_prog_seq`

## Requirements
- R1: After a word address is loaded, each of the first eight data bytes is acknowledged. Each byte is stored at latch index `ptr[2:0]`. Only `ptr[2:0]` then advances, wrapping from 7 to 0, and `ptr[7:3]` stays fixed.
- R2: A ninth or later data byte in the same transfer is not acknowledged. The following STOP then starts no programming and discards the collected bytes.
- R3: `busy` rises in the cycle after a STOP only if the transfer had a word address, at least one accepted byte and no overflow.
- R4: A transfer that carries a word address and no data bytes loads that address into `ptr_out`. Its STOP starts no programming.
- R5: While `busy` is high, `byte_ack` stays low and address loads, bytes, STOP and START change nothing. This includes an event that arrives in the cycle of the last write strobe.
- R6: Programming issues one `arr_erase` pulse with `arr_addr = {ptr[7:3],3'b000}`. It then issues one `arr_we` pulse per loaded entry, with `arr_addr = {ptr[7:3],index}` and that entry's byte, in ascending index order. Every step lasts DIV_A*DIV_B oscillator ticks, and the strobe comes at the end of its step. The two strobes are never high together.
- R7: `busy` falls exactly one clock after the last `arr_we` pulse. The latch is empty for the next transfer.
- R8: A START that arrives before STOP discards the bytes collected so far, so a later STOP programs nothing.
- R9: After reset, `busy`, `arr_we`, `arr_erase` and `byte_ack` are low and `ptr_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Internal oscillator tick that feeds the step timer |
| addr_load | input | 1 | One-cycle pulse: word address received |
| addr_in | input | 8 | Word address that goes with `addr_load` |
| byte_valid | input | 1 | One-cycle pulse: write data byte received |
| byte_in | input | 8 | Data byte that goes with `byte_valid` |
| stop_seen | input | 1 | STOP condition detected |
| start_seen | input | 1 | START condition detected |
| byte_ack | output | 1 | The offered data byte may be acknowledged (combinational) |
| busy | output | 1 | Programming sequence in progress |
| ptr_out | output | 8 | Current word address pointer |
| arr_we | output | 1 | Array program strobe, one cycle |
| arr_erase | output | 1 | Page erase strobe, one cycle |
| arr_addr | output | 8 | Array address for the strobe |
| arr_data | output | 8 | Array data for the program strobe |

## Verification
The critical coincidence is a bus event that lands in the same cycle as the final program strobe, and in the cycle after it, where `busy` falls. The bench provokes it by holding `addr_load` and `byte_valid` high for the whole sequence and releasing them only after the last `arr_we` has been seen. A behavioural model compares every clock and expects the new address to be ignored. It expects `busy` to drop one cycle after the strobe, and it expects the pointer to keep the value the transfer left in it. An irregular oscillator tick pattern also shifts the step boundaries against the bus events, so the step timing is checked under a range of alignments.

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int PB    = 3,
  parameter int DIV_A = 128,
  parameter int DIV_B = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_tick,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_in,
  input  logic          stop_seen,
  input  logic          start_seen,
  output logic          byte_ack,
  output logic          busy,
  output logic [AW-1:0] ptr_out,
  output logic          arr_we,
  output logic          arr_erase,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data
);
  localparam int PAGE = 1 << PB;
  localparam int CW   = $clog2(PAGE + 1);
  localparam int WA   = $clog2(DIV_A);
  localparam int WB   = $clog2(DIV_B);

  logic [AW-1:0]   ptr;
  logic            active, ovf, erase_pend, fin;
  logic [CW-1:0]   cnt;
  logic [PAGE-1:0] mask;
  logic [DW-1:0]   lat [PAGE];
  logic [WA-1:0]   pre_cnt;
  logic [WB-1:0]   stp_cnt;
  logic [PB-1:0]   nxt;
  logic            tick_a, step_end;

  assign ptr_out  = ptr;
  assign byte_ack = byte_valid & ~busy & active & ~ovf & (cnt < CW'(PAGE));
  assign tick_a   = osc_tick & (pre_cnt == WA'(DIV_A - 1));
  assign step_end = busy & ~fin & tick_a & (stp_cnt == WB'(DIV_B - 1));

  always_comb begin
    nxt = '0;
    for (int i = PAGE - 1; i >= 0; i--)
      if (mask[i]) nxt = PB'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0; active <= 1'b0; ovf <= 1'b0; cnt <= '0; mask <= '0;
      busy <= 1'b0; erase_pend <= 1'b0; fin <= 1'b0;
      pre_cnt <= '0; stp_cnt <= '0;
      arr_we <= 1'b0; arr_erase <= 1'b0; arr_addr <= '0; arr_data <= '0;
      for (int i = 0; i < PAGE; i++) lat[i] <= '0;
    end else begin
      arr_we    <= 1'b0;
      arr_erase <= 1'b0;
      if (busy) begin
        if (fin) begin
          busy <= 1'b0;
          fin  <= 1'b0;
          mask <= '0;
          cnt  <= '0;
          for (int i = 0; i < PAGE; i++) lat[i] <= '0;
        end else begin
          if (osc_tick) begin
            pre_cnt <= tick_a ? '0 : pre_cnt + WA'(1);
            if (tick_a) stp_cnt <= (stp_cnt == WB'(DIV_B - 1)) ? '0 : stp_cnt + WB'(1);
          end
          if (step_end) begin
            if (erase_pend) begin
              arr_erase  <= 1'b1;
              arr_addr   <= {ptr[AW-1:PB], {PB{1'b0}}};
              erase_pend <= 1'b0;
            end else begin
              arr_we    <= 1'b1;
              arr_addr  <= {ptr[AW-1:PB], nxt};
              arr_data  <= lat[nxt];
              mask[nxt] <= 1'b0;
              fin       <= ((mask & ~(PAGE'(1) << nxt)) == '0);
            end
          end
        end
      end else if (stop_seen) begin
        active <= 1'b0;
        ovf    <= 1'b0;
        cnt    <= '0;
        if (active & ~ovf & (|mask)) begin
          busy       <= 1'b1;
          erase_pend <= 1'b1;
          pre_cnt    <= '0;
          stp_cnt    <= '0;
        end else begin
          mask <= '0;
        end
      end else if (start_seen) begin
        active <= 1'b0; ovf <= 1'b0; cnt <= '0; mask <= '0;
      end else if (addr_load) begin
        ptr <= addr_in; active <= 1'b1; ovf <= 1'b0; cnt <= '0; mask <= '0;
      end else if (byte_valid & active) begin
        if (byte_ack) begin
          lat[ptr[PB-1:0]]  <= byte_in;
          mask[ptr[PB-1:0]] <= 1'b1;
          ptr[PB-1:0]       <= ptr[PB-1:0] + PB'(1);
          cnt               <= cnt + CW'(1);
        end else begin
          ovf <= 1'b1;
        end
      end
    end
  end

  p_no_ack_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ack);
  p_ptr_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(ptr));
  p_upper_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(addr_load) |-> ptr[AW-1:PB] == $past(ptr[AW-1:PB]));
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_we && arr_erase));
  p_strobe_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we || arr_erase) |-> busy);
  p_fall_after_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(arr_we));
  p_start_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_seen));
endmodule

// File: tb/page_prog_seq_bench.sv
module page_prog_seq_bench;
  localparam int DA = 4, DB = 2, STEP = DA * DB;

  logic clk = 0, rst_n = 0, osc_tick = 0;
  logic addr_load = 0, byte_valid = 0, stop_seen = 0, start_seen = 0;
  logic [7:0] addr_in = 0, byte_in = 0;
  logic byte_ack, busy, arr_we, arr_erase;
  logic [7:0] ptr_out, arr_addr, arr_data;

  page_prog_seq #(.DIV_A(DA), .DIV_B(DB)) u_page_prog_seq (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_in(byte_in),
    .stop_seen(stop_seen), .start_seen(start_seen),
    .byte_ack(byte_ack), .busy(busy), .ptr_out(ptr_out),
    .arr_we(arr_we), .arr_erase(arr_erase), .arr_addr(arr_addr), .arr_data(arr_data));

  always #10 clk = ~clk;

  int errs = 0, checks = 0, cycles = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ptr, m_cnt, m_timer, m_addr, m_data, m_page, idx;
  bit m_act, m_ovf, m_busy, m_epend, m_fin, m_we, m_er;
  int m_lat[8];
  bit m_has[8];
  int m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_cnt = 0; m_timer = 0; m_act = 0; m_ovf = 0;
      m_busy = 0; m_epend = 0; m_fin = 0; m_we = 0; m_er = 0;
      m_q.delete();
      for (int i = 0; i < 8; i++) m_has[i] = 0;
    end else begin
      m_we = 0; m_er = 0;
      if (m_busy) begin
        if (m_fin) begin
          m_busy = 0; m_fin = 0; m_cnt = 0;
          for (int i = 0; i < 8; i++) m_has[i] = 0;
        end else if (osc_tick) begin
          m_timer++;
          if (m_timer == STEP) begin
            m_timer = 0;
            if (m_epend) begin
              m_er = 1; m_addr = m_page * 8; m_epend = 0;
            end else begin
              idx = m_q.pop_front();
              m_we = 1; m_addr = m_page * 8 + idx; m_data = m_lat[idx];
              if (m_q.size() == 0) m_fin = 1;
            end
          end
        end
      end else if (stop_seen) begin
        if (m_act && !m_ovf && m_cnt > 0) begin
          m_busy = 1; m_epend = 1; m_timer = 0; m_page = m_ptr / 8;
          m_q.delete();
          for (int i = 0; i < 8; i++) if (m_has[i]) m_q.push_back(i);
        end
        for (int i = 0; i < 8; i++) m_has[i] = 0;
        m_act = 0; m_ovf = 0; m_cnt = 0;
      end else if (start_seen) begin
        for (int i = 0; i < 8; i++) m_has[i] = 0;
        m_act = 0; m_ovf = 0; m_cnt = 0;
      end else if (addr_load) begin
        m_ptr = addr_in; m_act = 1; m_ovf = 0; m_cnt = 0;
        for (int i = 0; i < 8; i++) m_has[i] = 0;
      end else if (byte_valid && m_act) begin
        if (m_cnt < 8 && !m_ovf) begin
          m_lat[m_ptr % 8] = byte_in; m_has[m_ptr % 8] = 1;
          m_ptr = (m_ptr & 'hF8) | ((m_ptr + 1) & 7);
          m_cnt++;
        end else m_ovf = 1;
      end
    end
  end

  always @(negedge clk) begin
    #8;
    if (rst_n) begin
      chk(m_busy ? "R5 ack while busy" : (m_cnt >= 8 ? "R2 ack after eighth" : "R1 ack"),
          byte_ack, int'(byte_valid && !m_busy && m_act && !m_ovf && m_cnt < 8));
      chk("R3 busy", busy, m_busy);
      chk("R6 erase strobe", arr_erase, m_er);
      chk("R6 write strobe", arr_we, m_we);
      if (m_we || m_er) chk("R6 array address", arr_addr, m_addr);
      if (m_we) chk("R6 array data", arr_data, m_data);
      chk("R1 pointer", ptr_out, m_ptr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk); #1;
      tc++;
      osc_tick = (tc % 3) != 0;
    end
  end

  task automatic do_addr(input logic [7:0] a);
    @(negedge clk); #1 addr_load = 1; addr_in = a;
    @(negedge clk); #1 addr_load = 0;
  endtask
  task automatic do_byte(input logic [7:0] d);
    @(negedge clk); #1 byte_valid = 1; byte_in = d;
    @(negedge clk); #1 byte_valid = 0;
  endtask
  task automatic do_stop();
    @(negedge clk); #1 stop_seen = 1;
    @(negedge clk); #1 stop_seen = 0;
  endtask
  task automatic do_start();
    @(negedge clk); #1 start_seen = 1;
    @(negedge clk); #1 start_seen = 0;
  endtask
  task automatic wait_idle();
    do begin @(negedge clk); #8; end while (busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int nwe;
    repeat (3) @(negedge clk);
    #8;
    chk("R9 busy after reset", busy, 0);
    chk("R9 write strobe after reset", arr_we, 0);
    chk("R9 pointer after reset", ptr_out, 0);
    @(negedge clk); #1 rst_n = 1;

    // two bytes inside one page
    do_addr(8'h13); do_byte(8'hA1); do_byte(8'hB2); do_stop();
    wait_idle();

    // full page starting mid-page, wrapping low bits
    do_addr(8'h2D);
    for (int i = 0; i < 8; i++) do_byte(8'h40 + 8'(i));
    @(negedge clk); #8 chk("R1 pointer wrapped within page", ptr_out, 'h2D);
    do_stop(); wait_idle();

    // single byte at the top address
    do_addr(8'hFF); do_byte(8'h5A);
    @(negedge clk); #8 chk("R1 upper bits kept on wrap", ptr_out, 'hF8);
    do_stop(); wait_idle();

    // ninth byte overflow
    do_addr(8'h40);
    for (int i = 0; i < 9; i++) do_byte(8'h10 + 8'(i));
    do_stop();
    repeat (4) @(negedge clk); #8;
    chk("R2 no programming after overflow", busy, 0);

    // address only
    do_addr(8'h77); do_stop();
    repeat (4) @(negedge clk); #8;
    chk("R4 pointer loaded", ptr_out, 'h77);
    chk("R4 no programming", busy, 0);

    // START discards collected bytes
    do_addr(8'h50); do_byte(8'h01); do_byte(8'h02); do_byte(8'h03);
    do_start(); do_stop();
    repeat (4) @(negedge clk); #8;
    chk("R8 no programming after restart", busy, 0);

    // bus activity throughout busy, including the last strobe cycle
    do_addr(8'h60); do_byte(8'hC0); do_byte(8'hC1); do_byte(8'hC2); do_stop();
    addr_load = 1; addr_in = 8'hAA; byte_valid = 1; byte_in = 8'hEE;
    nwe = 0;
    while (nwe < 3) begin
      @(negedge clk); #8;
      if (arr_we) nwe++;
    end
    chk("R7 busy high with last strobe", busy, 1);
    @(negedge clk); #1 addr_load = 0; byte_valid = 0;
    #7;
    chk("R7 busy low one cycle after last strobe", busy, 0);
    chk("R5 pointer unchanged by ignored load", ptr_out, 'h63);
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule